// File: doc/BRIEF.md
# Flash command interface decoder

This block sits behind the host bus of a partitioned NOR flash and turns the stream of bus writes into operation requests. Every write carries an address and a 16-bit data word, and the low byte of the data is the command code. Some commands change how one partition answers reads: array, identifier, query or status. The others are one- or two-cycle setup/confirm pairs, or the variable-length page-buffer load. Each accepted operation leaves the block as a one-cycle request with its kind, its latched address and its data word.

The block also keeps a small status register, a lock bit and a lock-down bit for each block, and the partition configuration value. The embedded algorithms are outside the block. A request that starts an algorithm marks the device busy, and the `op_done` input ends it. Array and query reads return stub data.

The write strobe `wr_en` is a one-cycle pulse, already synchronous, that stands for the moment the first of the bus write strobes rises. The address and data are captured on that clock edge.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, every partition is in array read mode, the status word reads 0x0080, no block is locked or locked down, and `op_valid` is 0. An array read returns the bitwise inverse of address bits 15:0.
- R2: The codes FFh (array), 90h (identifier), 98h (query) and 70h (status) change the read mode of only the partition that holds the address. The partition is address bits 19:18 and the block is bits 19:16. In identifier mode, address bits 1:0 select the value: 0 gives 0x00B0, 1 gives 0x00E0, 2 gives {lock-down, lock} of the addressed block in bits 1:0, and 3 gives the configuration value. In query mode a read returns {0x51, address bits 7:0}. Reads return data one cycle after `rd_en`.
- R3: Code 50h clears the sequence-error and lock-error bits.
- R4: Block erase is 20h and then D0h at the same address. It issues kind 1 with the first-cycle address and data 0. The status ready bit (bit 7) then reads 0 until `op_done` is seen.
- R5: Chip erase is 30h and then D0h at the same address. It issues kind 2, and it is refused when any block is locked.
- R6: Word program is 40h or 10h, followed by a cycle with the same address that carries the data word. It issues kind 3 with that word.
- R7: Page-buffer program is E8h, then a count cycle at the same address giving N-1, then N words in the same block, then D0h at an address in that block. Each word issues kind 4 with its address and data. The confirm issues kind 5 with the start address and data N-1. A count of 32 or more is a sequence error, and so is a word or confirm outside the block.
- R8: The prefix 60h is followed, at the same address, by one of four codes. 01h sets the lock bit (kind 8). D0h clears it (kind 9). 2Fh sets lock-down (kind 10). 04h loads the configuration value from address bits 15:0 and issues kind 11 with that value as data. On a locked-down block, 01h and D0h are refused, and lock-down clears only at reset.
- R9: A second cycle whose address differs from the first, or whose confirm code is not legal, sets status bit 4 (sequence error), issues nothing and returns to idle.
- R10: Erase, chip erase, program or page-buffer program that targets a locked block sets status bit 1 (lock error) and issues nothing.
- R11: While busy, only 70h and B0h take effect. Every other write changes nothing.
- R12: B0h while busy issues kind 6. The `op_done` that follows sets status bit 6 (suspended) and the ready bit. While suspended, only the read-mode codes, 50h and D0h act. D0h issues kind 7, clears bit 6 and makes the device busy again. D0h when nothing is suspended is a sequence error.
- R13: The first cycle of any operation command (20h, 30h, 40h, 10h, E8h, 60h, B0h) puts the addressed partition into status mode. An unknown first-cycle code sets the sequence-error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 20 | Write address |
| wr_data | input | 16 | Write data; low byte is the command code |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 20 | Read address |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |
| op_done | input | 1 | Embedded operation finished or suspended |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 4 | Operation kind code |
| op_addr | output | 20 | Latched operation address |
| op_data | output | 16 | Latched operation data |

## Verification
Every result registers on the edge that captures the stimulus. An operation request appears on the edge that takes its last write and lasts one cycle. Read data appears on the edge that takes `rd_en`. Status, mode and lock changes made by a write are visible to a read issued in the next cycle. The bench drives each stimulus for exactly one edge and samples one nanosecond after that edge, so every check sees the first cycle in which the result is due.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W   = 20,
  parameter int BLK_W    = 4,
  parameter int PART_W   = 2,
  parameter int PB_DEPTH = 32,
  parameter logic [15:0] MFR_CODE = 16'h00B0,
  parameter logic [15:0] DEV_CODE = 16'h00E0,
  parameter logic [7:0]  QRY_TAG  = 8'h51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  input  logic              op_done,
  output logic              op_valid,
  output logic [3:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [15:0]       op_data
);
  localparam int NBLK  = 1 << BLK_W;
  localparam int NPART = 1 << PART_W;
  localparam int CNT_W = $clog2(PB_DEPTH);
  localparam logic [15:0] PB_LIM = 16'(PB_DEPTH);

  localparam logic [3:0] K_ERASE = 4'd1, K_CHIP = 4'd2, K_PROG = 4'd3,
                         K_PBWORD = 4'd4, K_PBPROG = 4'd5, K_SUSP = 4'd6,
                         K_RESUME = 4'd7, K_LOCK = 4'd8, K_UNLOCK = 4'd9,
                         K_LKDN = 4'd10, K_CONFIG = 4'd11;

  typedef enum logic [1:0] {M_ARR, M_ID, M_QRY, M_STS} mode_t;
  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_CHIP, S_PROG,
                            S_PBCNT, S_PBDAT, S_PBCONF, S_CFG} st_t;

  st_t               st;
  mode_t             mode [NPART];
  logic [ADDR_W-1:0] seq_addr;
  logic [CNT_W-1:0]  pb_cnt, pb_n;
  logic              busy, susp, susp_pend, seqerr, lockerr;
  logic [NBLK-1:0]   lk, lkdn;
  logic [15:0]       pcr;

  wire [7:0]        cmd     = wr_data[7:0];
  wire [BLK_W-1:0]  wblk    = wr_addr[ADDR_W-1 -: BLK_W];
  wire [PART_W-1:0] wpart   = wr_addr[ADDR_W-1 -: PART_W];
  wire [BLK_W-1:0]  sblk    = seq_addr[ADDR_W-1 -: BLK_W];
  wire [BLK_W-1:0]  rblk    = rd_addr[ADDR_W-1 -: BLK_W];
  wire [PART_W-1:0] rpart   = rd_addr[ADDR_W-1 -: PART_W];
  wire              addr_ok = (wr_addr == seq_addr);
  wire              blk_ok  = (wblk == sblk);
  wire [15:0]       sts_w   = {8'h00, ~busy, susp, 1'b0, seqerr, 2'b00, lockerr, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      for (int i = 0; i < NPART; i++) mode[i] <= M_ARR;
      seq_addr  <= '0;
      pb_cnt    <= '0;
      pb_n      <= '0;
      busy      <= 1'b0;
      susp      <= 1'b0;
      susp_pend <= 1'b0;
      seqerr    <= 1'b0;
      lockerr   <= 1'b0;
      lk        <= '0;
      lkdn      <= '0;
      pcr       <= '0;
      op_valid  <= 1'b0;
      op_kind   <= '0;
      op_addr   <= '0;
      op_data   <= '0;
    end else begin
      op_valid <= 1'b0;
      if (op_done && busy) begin
        busy <= 1'b0;
        if (susp_pend) begin
          susp      <= 1'b1;
          susp_pend <= 1'b0;
        end
      end
      if (wr_en) begin
        if (busy) begin
          if (cmd == 8'h70) mode[wpart] <= M_STS;
          else if (cmd == 8'hB0 && !susp_pend) begin
            susp_pend   <= 1'b1;
            mode[wpart] <= M_STS;
            op_valid <= 1'b1; op_kind <= K_SUSP; op_addr <= wr_addr; op_data <= '0;
          end
        end else begin
          unique case (st)
            S_IDLE: begin
              if (susp) begin
                case (cmd)
                  8'hFF: mode[wpart] <= M_ARR;
                  8'h90: mode[wpart] <= M_ID;
                  8'h98: mode[wpart] <= M_QRY;
                  8'h70: mode[wpart] <= M_STS;
                  8'h50: begin seqerr <= 1'b0; lockerr <= 1'b0; end
                  8'hD0: begin
                    susp <= 1'b0;
                    busy <= 1'b1;
                    op_valid <= 1'b1; op_kind <= K_RESUME; op_addr <= wr_addr; op_data <= '0;
                  end
                  default: ;
                endcase
              end else begin
                seq_addr <= wr_addr;
                case (cmd)
                  8'hFF: mode[wpart] <= M_ARR;
                  8'h90: mode[wpart] <= M_ID;
                  8'h98: mode[wpart] <= M_QRY;
                  8'h70: mode[wpart] <= M_STS;
                  8'h50: begin seqerr <= 1'b0; lockerr <= 1'b0; end
                  8'h20: begin st <= S_ERASE; mode[wpart] <= M_STS; end
                  8'h30: begin st <= S_CHIP;  mode[wpart] <= M_STS; end
                  8'h40, 8'h10: begin st <= S_PROG; mode[wpart] <= M_STS; end
                  8'hE8: begin st <= S_PBCNT; mode[wpart] <= M_STS; end
                  8'h60: begin st <= S_CFG;   mode[wpart] <= M_STS; end
                  8'hB0: mode[wpart] <= M_STS;
                  default: seqerr <= 1'b1;
                endcase
              end
            end
            S_ERASE, S_CHIP: begin
              st <= S_IDLE;
              if (!addr_ok || cmd != 8'hD0) seqerr <= 1'b1;
              else if ((st == S_ERASE) ? lk[sblk] : (|lk)) lockerr <= 1'b1;
              else begin
                busy <= 1'b1;
                op_valid <= 1'b1; op_kind <= (st == S_ERASE) ? K_ERASE : K_CHIP;
                op_addr <= seq_addr; op_data <= '0;
              end
            end
            S_PROG: begin
              st <= S_IDLE;
              if (!addr_ok) seqerr <= 1'b1;
              else if (lk[sblk]) lockerr <= 1'b1;
              else begin
                busy <= 1'b1;
                op_valid <= 1'b1; op_kind <= K_PROG; op_addr <= seq_addr; op_data <= wr_data;
              end
            end
            S_PBCNT: begin
              if (!addr_ok || wr_data >= PB_LIM) begin
                seqerr <= 1'b1;
                st     <= S_IDLE;
              end else begin
                pb_cnt <= wr_data[CNT_W-1:0];
                pb_n   <= wr_data[CNT_W-1:0];
                st     <= S_PBDAT;
              end
            end
            S_PBDAT: begin
              if (!blk_ok) begin
                seqerr <= 1'b1;
                st     <= S_IDLE;
              end else begin
                op_valid <= 1'b1; op_kind <= K_PBWORD; op_addr <= wr_addr; op_data <= wr_data;
                if (pb_cnt == '0) st <= S_PBCONF;
                else pb_cnt <= pb_cnt - 1'b1;
              end
            end
            S_PBCONF: begin
              st <= S_IDLE;
              if (!blk_ok || cmd != 8'hD0) seqerr <= 1'b1;
              else if (lk[sblk]) lockerr <= 1'b1;
              else begin
                busy <= 1'b1;
                op_valid <= 1'b1; op_kind <= K_PBPROG; op_addr <= seq_addr; op_data <= 16'(pb_n);
              end
            end
            S_CFG: begin
              st <= S_IDLE;
              if (!addr_ok) seqerr <= 1'b1;
              else begin
                case (cmd)
                  8'h01, 8'hD0: begin
                    if (lkdn[sblk]) lockerr <= 1'b1;
                    else begin
                      lk[sblk] <= (cmd == 8'h01);
                      op_valid <= 1'b1; op_kind <= (cmd == 8'h01) ? K_LOCK : K_UNLOCK;
                      op_addr <= seq_addr; op_data <= '0;
                    end
                  end
                  8'h2F: begin
                    lkdn[sblk] <= 1'b1;
                    op_valid <= 1'b1; op_kind <= K_LKDN; op_addr <= seq_addr; op_data <= '0;
                  end
                  8'h04: begin
                    pcr <= seq_addr[15:0];
                    op_valid <= 1'b1; op_kind <= K_CONFIG; op_addr <= seq_addr;
                    op_data <= seq_addr[15:0];
                  end
                  default: seqerr <= 1'b1;
                endcase
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      unique case (mode[rpart])
        M_ARR: rd_data <= ~rd_addr[15:0];
        M_ID: begin
          case (rd_addr[1:0])
            2'd0: rd_data <= MFR_CODE;
            2'd1: rd_data <= DEV_CODE;
            2'd2: rd_data <= {14'b0, lkdn[rblk], lk[rblk]};
            default: rd_data <= pcr;
          endcase
        end
        M_QRY: rd_data <= {QRY_TAG, rd_addr[7:0]};
        default: rd_data <= sts_w;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int NBLK = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [3:0]      op_kind,
  input logic            busy,
  input logic            susp,
  input logic            seqerr,
  input logic            lockerr,
  input logic [NBLK-1:0] lkdn
);
  // R4
  busy_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_kind == 4'd1 || op_kind == 4'd2 || op_kind == 4'd3 ||
                 op_kind == 4'd5 || op_kind == 4'd7) |-> busy);

  // R9
  seqerr_no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seqerr) |-> !op_valid);

  // R10
  lockerr_no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockerr) |-> !op_valid);

  // R11
  busy_only_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && op_valid |-> op_kind == 4'd6);

  // R8
  lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkdn & $past(lkdn)) == $past(lkdn));

  // R12
  resume_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 4'd7 |-> !susp && busy);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .busy(busy), .susp(susp), .seqerr(seqerr), .lockerr(lockerr), .lkdn(lkdn)
);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, op_done = 1'b0;
  logic [19:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        op_valid;
  logic [3:0]  op_kind;
  logic [19:0] op_addr;
  logic [15:0] op_data;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .op_done(op_done),
    .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
  );

  typedef struct packed {
    logic [1:0]  act;
    logic [19:0] a;
    logic [15:0] d;
    logic        ev;
    logic [3:0]  ek;
    logic [15:0] ed;
    logic [15:0] erd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 109;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'hFFEF, 4'd1},   // R1
    '{2'd0, 20'h10010, 16'h0070, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd2},   // R2
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0080, 4'd1},
    '{2'd1, 20'h50000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'hFFFF, 4'd2},
    '{2'd0, 20'h50000, 16'h0090, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd2},
    '{2'd1, 20'h50000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h00B0, 4'd2},
    '{2'd1, 20'h50001, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h00E0, 4'd2},
    '{2'd1, 20'h50003, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd2},
    '{2'd0, 20'h10010, 16'h0098, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd2},
    '{2'd1, 20'h10023, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h5123, 4'd2},
    '{2'd0, 20'h10010, 16'h00FF, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd2},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'hFFEF, 4'd2},
    '{2'd0, 20'h10010, 16'h0020, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd4},   // R4
    '{2'd0, 20'h10010, 16'h00D0, 1'b1, 4'd1, 16'h0000, 16'h0000, 4'd4},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd4},   // R13 status mode
    '{2'd2, 20'h00000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd4},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0080, 4'd4},
    '{2'd0, 20'h00000, 16'h0030, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd5},   // R5
    '{2'd0, 20'h00000, 16'h00D0, 1'b1, 4'd2, 16'h0000, 16'h0000, 4'd5},
    '{2'd2, 20'h00000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd5},
    '{2'd0, 20'h20004, 16'h0040, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd6},   // R6
    '{2'd0, 20'h20004, 16'h1234, 1'b1, 4'd3, 16'h1234, 16'h0000, 4'd6},
    '{2'd2, 20'h00000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd6},
    '{2'd0, 20'h20008, 16'h0010, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd6},
    '{2'd0, 20'h20008, 16'hBEEF, 1'b1, 4'd3, 16'hBEEF, 16'h0000, 4'd6},
    '{2'd2, 20'h00000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd6},
    '{2'd0, 20'h10010, 16'h0020, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd9},   // R9 address mismatch
    '{2'd0, 20'h10011, 16'h00D0, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd9},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0090, 4'd9},
    '{2'd0, 20'h10010, 16'h0050, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd3},   // R3
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0080, 4'd3},
    '{2'd0, 20'h10010, 16'h0060, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd9},   // R9 bad confirm
    '{2'd0, 20'h10010, 16'h0055, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd9},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0090, 4'd9},
    '{2'd0, 20'h10010, 16'h0050, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd3},
    '{2'd0, 20'h10010, 16'h00AA, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd13},  // R13 unknown code
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0090, 4'd13},
    '{2'd0, 20'h10010, 16'h0050, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd3},
    '{2'd0, 20'h30000, 16'h0060, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd8},   // R8 lock block 3
    '{2'd0, 20'h30000, 16'h0001, 1'b1, 4'd8, 16'h0000, 16'h0000, 4'd8},
    '{2'd0, 20'h30000, 16'h0020, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd10},  // R10 erase refused
    '{2'd0, 20'h30000, 16'h00D0, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd10},
    '{2'd1, 20'h30000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0082, 4'd10},
    '{2'd0, 20'h30000, 16'h0050, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd3},
    '{2'd0, 20'h30000, 16'h0040, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd10},  // program refused
    '{2'd0, 20'h30000, 16'h5555, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd10},
    '{2'd1, 20'h30000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0082, 4'd10},
    '{2'd0, 20'h30000, 16'h0050, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd3},
    '{2'd0, 20'h00000, 16'h0030, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd5},   // chip erase refused
    '{2'd0, 20'h00000, 16'h00D0, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd5},
    '{2'd1, 20'h00000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0082, 4'd5},
    '{2'd0, 20'h00000, 16'h0050, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd3},
    '{2'd0, 20'h30000, 16'h0090, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd8},
    '{2'd1, 20'h30002, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0001, 4'd8},
    '{2'd0, 20'h30000, 16'h0060, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd8},   // unlock
    '{2'd0, 20'h30000, 16'h00D0, 1'b1, 4'd9, 16'h0000, 16'h0000, 4'd8},
    '{2'd0, 20'h60000, 16'h0060, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd8},   // lock-down block 6
    '{2'd0, 20'h60000, 16'h002F, 1'b1, 4'd10, 16'h0000, 16'h0000, 4'd8},
    '{2'd0, 20'h60000, 16'h0060, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd8},
    '{2'd0, 20'h60000, 16'h0001, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd8},
    '{2'd1, 20'h60000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0082, 4'd8},
    '{2'd0, 20'h60000, 16'h0050, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd3},
    '{2'd0, 20'h60000, 16'h0090, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd8},
    '{2'd1, 20'h60002, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0002, 4'd8},
    '{2'd0, 20'h01234, 16'h0060, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd8},   // configuration value
    '{2'd0, 20'h01234, 16'h0004, 1'b1, 4'd11, 16'h1234, 16'h0000, 4'd8},
    '{2'd0, 20'h00000, 16'h0090, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd8},
    '{2'd1, 20'h00003, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h1234, 4'd8},
    '{2'd0, 20'h20000, 16'h00E8, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd7},   // R7 three words
    '{2'd0, 20'h20000, 16'h0002, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd7},
    '{2'd0, 20'h20000, 16'hAAAA, 1'b1, 4'd4, 16'hAAAA, 16'h0000, 4'd7},
    '{2'd0, 20'h20001, 16'hBBBB, 1'b1, 4'd4, 16'hBBBB, 16'h0000, 4'd7},
    '{2'd0, 20'h20002, 16'hCCCC, 1'b1, 4'd4, 16'hCCCC, 16'h0000, 4'd7},
    '{2'd0, 20'h20007, 16'h00D0, 1'b1, 4'd5, 16'h0002, 16'h0000, 4'd7},
    '{2'd1, 20'h20000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd7},
    '{2'd2, 20'h00000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd7},
    '{2'd0, 20'h20000, 16'h00E8, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd7},   // count too large
    '{2'd0, 20'h20000, 16'h0020, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd7},
    '{2'd1, 20'h20000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0090, 4'd7},
    '{2'd0, 20'h20000, 16'h0050, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd3},
    '{2'd0, 20'h20000, 16'h00E8, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd7},   // word outside block
    '{2'd0, 20'h20000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd7},
    '{2'd0, 20'h30000, 16'h1111, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd7},
    '{2'd1, 20'h20000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0090, 4'd7},
    '{2'd0, 20'h20000, 16'h0050, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd3},
    '{2'd0, 20'h10010, 16'h0020, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd11},  // R11 busy ignores
    '{2'd0, 20'h10010, 16'h00D0, 1'b1, 4'd1, 16'h0000, 16'h0000, 4'd11},
    '{2'd0, 20'h05555, 16'h0060, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd11},
    '{2'd0, 20'h05555, 16'h0004, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd11},
    '{2'd0, 20'h10010, 16'h00FF, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd11},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd11},
    '{2'd2, 20'h00000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd11},
    '{2'd0, 20'h00000, 16'h0090, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd11},
    '{2'd1, 20'h00003, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h1234, 4'd11},
    '{2'd0, 20'h10010, 16'h0020, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd12},  // R12 suspend/resume
    '{2'd0, 20'h10010, 16'h00D0, 1'b1, 4'd1, 16'h0000, 16'h0000, 4'd12},
    '{2'd0, 20'h10010, 16'h00B0, 1'b1, 4'd6, 16'h0000, 16'h0000, 4'd12},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd12},
    '{2'd2, 20'h00000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd12},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h00C0, 4'd12},
    '{2'd0, 20'h10010, 16'h0040, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd12},
    '{2'd0, 20'h10010, 16'h00D0, 1'b1, 4'd7, 16'h0000, 16'h0000, 4'd12},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd12},
    '{2'd2, 20'h00000, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd12},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0080, 4'd12},
    '{2'd0, 20'h10010, 16'h00D0, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd12},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0090, 4'd12},
    '{2'd0, 20'h10010, 16'h0050, 1'b0, 4'd0, 16'h0000, 16'h0000, 4'd3},
    '{2'd1, 20'h10010, 16'h0000, 1'b0, 4'd0, 16'h0000, 16'h0080, 4'd3}
  };

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] act, input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en   = (act == 2'd0);
    rd_en   = (act == 2'd1);
    op_done = (act == 2'd2);
    wr_addr = a; rd_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; op_done = 1'b0;
  endtask

  task automatic expect_op(input int rq, input logic v, input logic [3:0] k);
    check(op_valid == v, rq, "op_valid", 32'(op_valid), 32'(v));
    if (v) check(op_kind == k, rq, "op_kind", 32'(op_kind), 32'(k));
  endtask

  task automatic expect_rd(input int rq, input logic [15:0] e);
    check(rd_data == e, rq, "rd_data", 32'(rd_data), 32'(e));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, 0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(op_valid == 1'b0, 1, "op_valid in reset", 32'(op_valid), 32'd0);  // R1
    @(negedge clk);
    rst_n = 1'b1;

    foreach (TBL[i]) begin
      step(TBL[i].act, TBL[i].a, TBL[i].d);
      if (TBL[i].act == 2'd1) expect_rd(int'(TBL[i].rq), TBL[i].erd);
      else begin
        expect_op(int'(TBL[i].rq), TBL[i].ev, TBL[i].ek);
        if (TBL[i].ev)
          check(op_data == TBL[i].ed, int'(TBL[i].rq), "op_data", 32'(op_data), 32'(TBL[i].ed));
      end
    end

    // R4: erase request carries the first-cycle address
    step(2'd0, 20'h20ABC, 16'h0020);
    step(2'd0, 20'h20ABC, 16'h00D0);
    expect_op(4, 1'b1, 4'd1);
    check(op_addr == 20'h20ABC, 4, "erase op_addr", 32'(op_addr), 32'h20ABC);
    step(2'd2, 20'h0, 16'h0);

    // R7: page-buffer confirm carries the start address
    step(2'd0, 20'h20010, 16'h00E8);
    step(2'd0, 20'h20010, 16'h0000);
    step(2'd0, 20'h20010, 16'h7777);
    expect_op(7, 1'b1, 4'd4);
    check(op_addr == 20'h20010, 7, "word op_addr", 32'(op_addr), 32'h20010);
    step(2'd0, 20'h2FFFF, 16'h00D0);
    expect_op(7, 1'b1, 4'd5);
    check(op_addr == 20'h20010, 7, "confirm op_addr", 32'(op_addr), 32'h20010);
    step(2'd2, 20'h0, 16'h0);

    // R1: reset clears locks and returns partitions to array mode
    step(2'd0, 20'h40000, 16'h0060);
    step(2'd0, 20'h40000, 16'h0001);
    expect_op(1, 1'b1, 4'd8);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check(op_valid == 1'b0, 1, "op_valid after reset", 32'(op_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'd1, 20'h50004, 16'h0);
    expect_rd(1, 16'hFFFB);
    step(2'd0, 20'h40000, 16'h0090);
    step(2'd1, 20'h40002, 16'h0);
    expect_rd(1, 16'h0000);
    step(2'd0, 20'h00000, 16'h0070);
    step(2'd1, 20'h00000, 16'h0);
    expect_rd(1, 16'h0080);

    finish_run();
  end
endmodule